// File: doc/BRIEF.md
# Multi-CPU interrupt routing controller

The block collects level-sensitive interrupt lines and routes each one to any of four CPUs. Software reaches it through a simple 32-bit register bus that has two windows. The global window holds the per-source enables, one routing word per source and a read-only word that reports the source count. The per-CPU window is banked by the `cpu_id_i` value that comes with each access. Each CPU bank holds that CPU's mask bits and an acknowledge word. A read of the acknowledge word returns the lowest-numbered source that is pending for that CPU.

Software never uses read-modify-write on enables or masks. It writes a source index to a set strobe or a clear strobe. Sources 0 and 1 (the summarised doorbell lines) and the timer source (`TIMER_SRC`, default 5) are private per-CPU sources. They skip the global enable and the routing word, and only the mask of each CPU gates them. Each CPU has a level output `irq_o[c]` that is high while anything is pending for it.

Bus reads return data on `rdata_o` in the cycle after the request. The bus has no handshake. A read of the acknowledge word has no side effect, because every source is level sensitive.

Top module: `irq_router`

## Requirements
- R1: A global read at offset 0x000 returns the implemented source count NUM_SRC in bits [11:2]. All other bits read 0.
- R2: A global write at 0x030 sets the enable of the source whose index is in wdata_i[9:0], and a write at 0x034 clears it. An index of NUM_SRC or above changes no enable.
- R3: The routing word of source n is at global offset 0x100 + 4*n. Bit c of the low 4 bits routes the source to CPU c. A write stores wdata_i[3:0], and a read returns those bits with bits [31:4] at 0. Words for n >= NUM_SRC read 0 and ignore writes.
- R4: A per-CPU write at 0x048 sets the mask bit of source wdata_i[9:0] for CPU cpu_id_i, and a write at 0x04C clears it. The banks of the other CPUs are unchanged.
- R5: A shared source n is pending for CPU c exactly when its line src_i[n] is high, it is enabled, routing bit c is set, and CPU c has it unmasked. irq_o[c] is high while any source is pending for CPU c.
- R6: A per-CPU read at 0x044 returns, in bits [9:0], the lowest pending source index for CPU cpu_id_i. Bits [31:10] are 0. The value is 1023 when nothing is pending.
- R7: Sources 0, 1 and TIMER_SRC ignore the enable and the routing word. Each is pending for CPU c when its line is high and CPU c has it unmasked.
- R8: After reset all enables are clear, all routing words are 0 and every mask bit of every CPU is set. So irq_o is 0 and every acknowledge read returns 1023, whatever the lines are.
- R9: Read data appears on rdata_o in the cycle after the request. Reads of unmapped offsets in either window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 1 | 0 = global window, 1 = per-CPU window |
| cpu_id_i | input | 2 | CPU issuing the access; selects the per-CPU bank |
| addr_i | input | 13 | Byte offset within the selected window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| irq_o | output | 4 | Per-CPU interrupt request |

## Verification
The hardest case to reach is one where the four gating conditions differ from CPU to CPU at the same time. A source can be enabled and routed to two CPUs while only one of them has it unmasked, and a lower-numbered private source must beat it on one CPU but not on the other. Directed steps build such states on purpose: one CPU masks a source while another unmasks it, and a private source is raised with its enable clear. A seeded random run then mixes strobes, routing writes and line changes. After each step it compares every CPU's acknowledge value and irq_o against a bench model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_CPU = 4;
  localparam int ID_W    = 10;
  localparam int ADDR_W  = 13;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  // global window
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 13'h000;
  localparam logic [ADDR_W-1:0] OFF_EN_SET = 13'h030;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR = 13'h034;
  localparam logic [ADDR_W-1:0] OFF_ROUTE  = 13'h100;
  // per-CPU window
  localparam logic [ADDR_W-1:0] OFF_ACK    = 13'h044;
  localparam logic [ADDR_W-1:0] OFF_MSK_ST = 13'h048;
  localparam logic [ADDR_W-1:0] OFF_MSK_CL = 13'h04C;

  function automatic logic is_private(int n, int timer_src);
    return (n == 0) || (n == 1) || (n == timer_src);
  endfunction
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              en_set_i,
  input  logic                              en_clr_i,
  input  logic [ID_W-1:0]                   idx_i,
  input  logic                              route_we_i,
  input  logic [ID_W-1:0]                   route_idx_i,
  input  logic [NUM_CPU-1:0]                route_data_i,
  output logic [NUM_SRC-1:0]                en_o,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_o
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic hit, rhit;
    assign hit  = (idx_i == ID_W'(n));
    assign rhit = route_we_i && (route_idx_i == ID_W'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[n]    <= 1'b0;
        route_o[n] <= '0;
      end else begin
        if (en_set_i && hit)      en_o[n] <= 1'b1;
        else if (en_clr_i && hit) en_o[n] <= 1'b0;
        if (rhit) route_o[n] <= route_data_i;
      end
    end
  end
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int TIMER_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msk_set_i,
  input  logic               msk_clr_i,
  input  logic [ID_W-1:0]    idx_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] route_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o,
  output logic [ID_W-1:0]    id_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic hit, gate;
    assign hit = (idx_i == ID_W'(n));
    // private sources bypass enable and routing
    if (is_private(n, TIMER_SRC)) begin : g_priv
      assign gate = 1'b1;
    end else begin : g_shr
      assign gate = en_i[n] & route_i[n];
    end
    assign elig[n] = src_i[n] & ~mask_o[n] & gate;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               mask_o[n] <= 1'b1;
      else if (msk_set_i && hit) mask_o[n] <= 1'b1;
      else if (msk_clr_i && hit) mask_o[n] <= 1'b0;
    end
  end

  assign irq_o = |elig;

  always_comb begin
    id_o = NONE_ID;
    for (int n = NUM_SRC - 1; n >= 0; n--)
      if (elig[n]) id_o = ID_W'(n);
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int TIMER_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               win_i,
  input  logic [1:0]         cpu_id_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam logic [ADDR_W-3:0] RT_LIM = (ADDR_W-2)'(NUM_SRC);

  logic                            acc_g, acc_c;
  logic [ID_W-1:0]                 idx;
  logic [ADDR_W-1:0]               roff;
  logic                            route_hit;
  logic [ID_W-1:0]                 route_idx;
  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
  logic [NUM_CPU*NUM_SRC-1:0]      mask_all;
  logic [NUM_CPU-1:0][ID_W-1:0]    ack_id;
  logic [31:0]                     rd_d;
  logic                            unused_wdata;

  assign acc_g        = req_i & ~win_i;
  assign acc_c        = req_i & win_i;
  assign idx          = wdata_i[ID_W-1:0];
  assign unused_wdata = ^wdata_i[31:ID_W];

  assign roff      = addr_i - OFF_ROUTE;
  assign route_hit = (addr_i >= OFF_ROUTE) && (roff[1:0] == 2'b00) &&
                     (roff[ADDR_W-1:2] < RT_LIM);
  assign route_idx = roff[ID_W+1:2];

  irq_src_regs #(.NUM_SRC(NUM_SRC)) u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_set_i     (acc_g && we_i && addr_i == OFF_EN_SET),
    .en_clr_i     (acc_g && we_i && addr_i == OFF_EN_CLR),
    .idx_i        (idx),
    .route_we_i   (acc_g && we_i && route_hit),
    .route_idx_i  (route_idx),
    .route_data_i (wdata_i[NUM_CPU-1:0]),
    .en_o         (en_q),
    .route_o      (route_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] route_col;
    logic               sel;
    assign sel = acc_c && we_i && (cpu_id_i == 2'(c));
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
      assign route_col[n] = route_q[n][c];
    end
    irq_cpu_bank #(.NUM_SRC(NUM_SRC), .TIMER_SRC(TIMER_SRC)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .msk_set_i (sel && addr_i == OFF_MSK_ST),
      .msk_clr_i (sel && addr_i == OFF_MSK_CL),
      .idx_i     (idx),
      .src_i     (src_i),
      .en_i      (en_q),
      .route_i   (route_col),
      .mask_o    (mask_all[c*NUM_SRC +: NUM_SRC]),
      .irq_o     (irq_o[c]),
      .id_o      (ack_id[c])
    );
  end

  always_comb begin
    rd_d = '0;
    if (!win_i) begin
      if (addr_i == OFF_CTRL) rd_d = 32'(NUM_SRC) << 2;
      else if (route_hit)
        for (int n = 0; n < NUM_SRC; n++)
          if (route_idx == ID_W'(n)) rd_d = {28'b0, route_q[n]};
    end else if (addr_i == OFF_ACK) begin
      rd_d = {22'b0, ack_id[cpu_id_i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_d;
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic                       win_i,
  input logic [1:0]                 cpu_id_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [31:0]                wdata_i,
  input logic [31:0]                rdata_o,
  input logic [NUM_SRC-1:0]         src_i,
  input logic [NUM_CPU-1:0]         irq_o,
  input logic [NUM_SRC-1:0]         en_q,
  input logic [NUM_CPU*NUM_SRC-1:0] mask_all
);
  logic [ID_W-1:0]            idx;
  logic                       idx_ok;
  logic [NUM_SRC-1:0]         en_sel;
  logic [NUM_CPU*NUM_SRC-1:0] msk_sel;

  assign idx     = wdata_i[ID_W-1:0];
  assign idx_ok  = (idx < ID_W'(NUM_SRC));
  assign en_sel  = {{(NUM_SRC-1){1'b0}}, 1'b1} << idx;
  assign msk_sel = {{(NUM_CPU*NUM_SRC-1){1'b0}}, 1'b1} << (32'(cpu_id_i) * NUM_SRC + 32'(idx));

  // R1
  ctrl_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !win_i && addr_i == OFF_CTRL |=> rdata_o == (32'(NUM_SRC) << 2));

  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !win_i && addr_i == OFF_EN_SET && idx_ok |=> |(en_q & $past(en_sel)));

  // R2
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !win_i && addr_i == OFF_EN_CLR && idx_ok |=> !(|(en_q & $past(en_sel))));

  // R4
  msk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && win_i && addr_i == OFF_MSK_ST && idx_ok |=> |(mask_all & $past(msk_sel)));

  // R4
  msk_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && win_i && addr_i == OFF_MSK_CL && idx_ok |=> !(|(mask_all & $past(msk_sel))));

  // R5
  no_line_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i == '0 |-> irq_o == '0);

  // R6
  ack_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && win_i && addr_i == OFF_ACK && !irq_o[cpu_id_i] |=> rdata_o == 32'd1023);
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .win_i    (win_i),
  .cpu_id_i (cpu_id_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .src_i    (src_i),
  .irq_o    (irq_o),
  .en_q     (en_q),
  .mask_all (mask_all)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int N  = 32;
  localparam int TM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, win = 1'b0;
  logic [1:0]  cpu = '0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] src = '0;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;

  logic [N-1:0] en_m;
  logic [3:0]   route_m [N];
  logic [N-1:0] mask_m  [4];

  irq_router #(.NUM_SRC(N), .TIMER_SRC(TM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .win_i(win),
    .cpu_id_i(cpu), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .src_i(src), .irq_o(irq)
  );

  always #2 clk = ~clk;

  function automatic logic elig(int c, int n);
    logic gate;
    gate = (n == 0 || n == 1 || n == TM) ? 1'b1 : (en_m[n] & route_m[n][c]);
    return src[n] & ~mask_m[c][n] & gate;
  endfunction

  function automatic logic [31:0] exp_ack(int c);
    for (int n = 0; n < N; n++) if (elig(c, n)) return n;
    return 32'd1023;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r = '0;
    for (int c = 0; c < 4; c++) r[c] = (exp_ack(c) != 32'd1023);
    return r;
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic w, int c, logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; win = w; cpu = 2'(c); addr = a; wdata = d;
    @(posedge clk);
    if (!w) begin
      if (a == 13'h030 && d[9:0] < N) en_m[d[9:0]] = 1'b1;
      if (a == 13'h034 && d[9:0] < N) en_m[d[9:0]] = 1'b0;
      if (a >= 13'h100 && a[1:0] == 2'b00 && ((a - 13'h100) >> 2) < N)
        route_m[(a - 13'h100) >> 2] = d[3:0];
    end else begin
      if (a == 13'h048 && d[9:0] < N) mask_m[c][d[9:0]] = 1'b1;
      if (a == 13'h04C && d[9:0] < N) mask_m[c][d[9:0]] = 1'b0;
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic w, int c, logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; win = w; cpu = 2'(c); addr = a;
    @(posedge clk);
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic set_src(logic [N-1:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic check_all_cpus(string tag);
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      rd(1'b1, c, 13'h044, d);
      check(tag, d, exp_ack(c));
    end
    #1 check(tag, {28'b0, irq}, {28'b0, exp_irq()});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    en_m = '0;
    for (int n = 0; n < N; n++) route_m[n] = '0;
    for (int c = 0; c < 4; c++) mask_m[c] = '1;
    src = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8 reset state: all lines high, yet nothing presented
    #1 check("R8 irq after reset", {28'b0, irq}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      rd(1'b1, c, 13'h044, d);
      check("R8 ack after reset", d, 32'd1023);
    end
    rd(1'b0, 0, 13'h100 + 13'd4 * 13'd7, d);
    check("R8 route after reset", d, 32'd0);

    // R1
    rd(1'b0, 0, 13'h000, d);
    check("R1 source count", d, 32'(N) << 2);

    // R9 unmapped offsets
    rd(1'b0, 0, 13'h020, d);
    check("R9 unmapped global", d, 32'd0);
    rd(1'b1, 2, 13'h010, d);
    check("R9 unmapped per-cpu", d, 32'd0);

    // R3 routing storage, upper bits dropped, out of range
    wr(1'b0, 0, 13'h100 + 13'd4 * 13'd9, 32'hFFFF_FFF6);
    rd(1'b0, 0, 13'h100 + 13'd4 * 13'd9, d);
    check("R3 route readback", d, 32'h6);
    wr(1'b0, 0, 13'h100 + 13'd4 * 13'(N), 32'hF);
    rd(1'b0, 0, 13'h100 + 13'd4 * 13'(N), d);
    check("R3 route out of range", d, 32'd0);

    // R5 shared source 9 routed to CPUs 1,2; enable and unmask on CPU1 only
    src = '0;
    set_src(32'h0000_0200);
    wr(1'b0, 0, 13'h030, 32'd9);
    wr(1'b1, 1, 13'h04C, 32'd9);
    check_all_cpus("R5 shared route");
    // R4 unmask on CPU2 does not touch CPU1, masking CPU1 leaves CPU2
    wr(1'b1, 2, 13'h04C, 32'd9);
    wr(1'b1, 1, 13'h048, 32'd9);
    check_all_cpus("R4 banked mask");
    // R2 clear enable removes it; out-of-range set has no effect
    wr(1'b0, 0, 13'h034, 32'd9);
    wr(1'b0, 0, 13'h030, 32'd40);
    check_all_cpus("R2 enable clear and bad index");
    wr(1'b0, 0, 13'h030, 32'd9);

    // R7 private timer with enable clear and route zero beats source 9 on CPU2
    wr(1'b1, 2, 13'h04C, 32'(TM));
    wr(1'b1, 0, 13'h04C, 32'(TM));
    set_src(32'h0000_0220);
    check_all_cpus("R7 private timer");
    // R6 lowest index wins: doorbell 1 unmasked on CPU2
    wr(1'b1, 2, 13'h04C, 32'd1);
    set_src(32'h0000_0222);
    check_all_cpus("R6 lowest index");
    rd(1'b1, 3, 13'h044, d);
    check("R6 none pending", d, 32'd1023);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      int n;
      int c;
      op = $urandom % 7;
      n  = $urandom % (N + 2);
      c  = $urandom % 4;
      case (op)
        0: wr(1'b0, 0, 13'h030, 32'(n));
        1: wr(1'b0, 0, 13'h034, 32'(n));
        2: wr(1'b0, 0, 13'h100 + 13'(4 * n), $urandom);
        3: wr(1'b1, c, 13'h048, 32'(n));
        4: wr(1'b1, c, 13'h04C, 32'(n));
        default: set_src($urandom);
      endcase
      rd(1'b1, c, 13'h044, d);
      check("R6 random ack", d, exp_ack(c));
      #1 check("R5 random irq", {28'b0, irq}, {28'b0, exp_irq()});
    end

    finish_run();
  end
endmodule